// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller

This block collects up to thirty-two interrupt request lines and turns them into two request outputs for a processor: a normal-class request and an urgent-class request. Each source is brought into the clock domain through a two-stage synchronizer. Each source can be set to fire on a level or on an edge, and to treat high/rising or low/falling as active. A detected event sets a sticky pending bit. Software clears a pending bit by writing a one to it.

A per-source enable gates the pending bits into a masked view. The masked view drives the two outputs, with the split chosen per source by a class register. A priority encoder reports the most urgent enabled pending source.

Bit numbering is MSB-first. Source 0 sits in bit 31 of every register and of the input vector, and it has the highest priority. Software reaches the block through a simple single-cycle register port. Writes take effect at the next rising edge, and read data is combinational from the address.

Top module: `uic_core`

## Requirements
- R1: Source n occupies bit (31 − n) of the input vector and of every register. Source 0 (bit 31) has the highest priority.
- R2: After reset, the enable, class, polarity and trigger registers all read zero. Both request outputs are low and the encoder reports "none".
- R3: The register map uses these word addresses: 0 pending status, 1 enable, 2 class, 3 polarity, 4 trigger, 5 masked status, 6 encoder. Address 5 reads pending status AND enable.
- R4: A trigger bit of 0 selects level mode. In level mode the pending bit is set on every cycle the adjusted input is active. A polarity bit of 1 means active-high and 0 means active-low. An input change reaches the pending bit on the third rising edge after it is applied.
- R5: A trigger bit of 1 selects edge mode. With polarity 1 a rising edge sets the pending bit, and with polarity 0 a falling edge sets it. The bit stays set after the input returns, and an input held steady does not set it again.
- R6: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. Writing all ones clears every bit whose source is not active in that cycle.
- R7: When a clear and an active level land in the same cycle, the level wins, so a level source stays pending until its input goes inactive and it is cleared. A pending bit with no clear write never drops.
- R8: The encoder register holds the number of the lowest-numbered masked pending source in bits [4:0] and a "none" flag in bit 8. When nothing is pending it reads 0x100. The pend_idx and pend_none ports carry the same values.
- R9: irq_nc is the OR of masked bits whose class bit is 0, and irq_cr is the OR of masked bits whose class bit is 1.
- R10: Writes to address 5 or 6 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Raw request lines, bit 31 = source 0 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_nc | output | 1 | Normal-class request |
| irq_cr | output | 1 | Urgent-class request |
| pend_idx | output | 5 | Highest-priority masked pending source |
| pend_none | output | 1 | No masked source pending |

## Verification
The main masking and routing path is driven with level inputs from a table. The table uses all-active-high and all-active-low polarity, a polarity split across the two half-words, an all-quiet case, and an enable mask that hides the highest-priority active source.

- Differing masked reads distinguish a wrong polarity sense from a wrong enable gating.
- The encoder values show whether the MSB-first priority is honoured.
- The output pair shows whether the class split is applied.

Directed sequences then cover the following:
- Count the three-edge input latency.
- Pit a clear against a held level.
- Compare rising and falling edge capture.
- Show that a held edge input does not re-arm.
- Write zeros into the pending register to show they leave it unchanged.
- Write to the read-only addresses to show nothing changes.

// File: rtl/uic_pkg.sv
package uic_pkg;
    typedef enum logic [2:0] {
        RA_STAT = 3'd0,
        RA_EN   = 3'd1,
        RA_CRIT = 3'd2,
        RA_POL  = 3'd3,
        RA_TRIG = 3'd4,
        RA_MSK  = 3'd5,
        RA_IDX  = 3'd6
    } uic_reg_e;

    localparam int NONE_BIT = 8;
endpackage

// File: rtl/uic_sync.sv
module uic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/uic_detect.sv
module uic_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] trig,
    output logic [W-1:0] set_vec
);
    logic [W-1:0] act;
    logic [W-1:0] act_q;

    // active when input matches polarity
    assign act = ~(lvl_in ^ pol);

    // history starts at the post-reset active value so no false edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '1;
        else        act_q <= act;
    end

    for (genvar i = 0; i < W; i++) begin : g_src
        always_comb begin
            if (trig[i]) set_vec[i] = act[i] & ~act_q[i];
            else         set_vec[i] = act[i];
        end
    end
endmodule

// File: rtl/uic_prio_enc.sv
module uic_prio_enc #(
    parameter int W    = 32,
    parameter int IDXW = $clog2(W)
) (
    input  logic [W-1:0]    msk,
    output logic [IDXW-1:0] idx,
    output logic            none
);
    always_comb begin
        idx  = '0;
        none = 1'b1;
        // later (higher) bits override: MSB = source 0 wins
        for (int i = 0; i < W; i++) begin
            if (msk[i]) begin
                idx  = IDXW'(W - 1 - i);
                none = 1'b0;
            end
        end
    end
endmodule

// File: rtl/uic_core.sv
module uic_core
    import uic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_src,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    output logic            irq_nc,
    output logic            irq_cr,
    output logic [IDXW-1:0] pend_idx,
    output logic            pend_none
);
    logic [NSRC-1:0] st_q, en_q, cr_q, pol_q, trig_q;
    logic [NSRC-1:0] sync_in;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] msk;
    logic [NSRC-1:0] clr_vec;
    uic_reg_e        sel;

    assign sel = uic_reg_e'(reg_addr);

    uic_sync #(.W(NSRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_src),
        .q     (sync_in)
    );

    uic_detect #(.W(NSRC)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_in  (sync_in),
        .pol     (pol_q),
        .trig    (trig_q),
        .set_vec (set_vec)
    );

    assign clr_vec = (reg_wr && sel == RA_STAT) ? reg_wdata : '0;

    // set takes priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            cr_q   <= '0;
            pol_q  <= '0;
            trig_q <= '0;
        end else if (reg_wr) begin
            unique case (sel)
                RA_EN:   en_q   <= reg_wdata;
                RA_CRIT: cr_q   <= reg_wdata;
                RA_POL:  pol_q  <= reg_wdata;
                RA_TRIG: trig_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign msk = st_q & en_q;

    uic_prio_enc #(.W(NSRC), .IDXW(IDXW)) u_enc (
        .msk  (msk),
        .idx  (pend_idx),
        .none (pend_none)
    );

    assign irq_nc = |(msk & ~cr_q);
    assign irq_cr = |(msk & cr_q);

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            RA_STAT: reg_rdata = st_q;
            RA_EN:   reg_rdata = en_q;
            RA_CRIT: reg_rdata = cr_q;
            RA_POL:  reg_rdata = pol_q;
            RA_TRIG: reg_rdata = trig_q;
            RA_MSK:  reg_rdata = msk;
            RA_IDX: begin
                reg_rdata[IDXW-1:0] = pend_idx;
                reg_rdata[NONE_BIT] = pend_none;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uic_core_chk.sv
module uic_core_chk #(
    parameter int NSRC = 32,
    parameter int IDXW = $clog2(NSRC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [2:0]      reg_addr,
    input logic [NSRC-1:0] reg_wdata,
    input logic [NSRC-1:0] st_q,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] cr_q,
    input logic [NSRC-1:0] set_vec,
    input logic            irq_nc,
    input logic            irq_cr,
    input logic [IDXW-1:0] pend_idx,
    input logic            pend_none
);
    logic [NSRC-1:0] live_msk;
    logic            stat_wr;
    assign live_msk = st_q & en_q;
    assign stat_wr  = reg_wr && (reg_addr == 3'd0);

    // R6: written ones are gone next cycle unless re-set
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((st_q & $past(reg_wdata) & ~$past(set_vec)) == '0));

    // R7: a set always lands, even against a clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & $past(set_vec)) == $past(set_vec)));

    // R7: pending bits are sticky without a clear write
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((st_q & $past(st_q)) == $past(st_q)));

    // R8: a reported index names an enabled pending source
    p_enc_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_none |-> live_msk[NSRC - 1 - int'(pend_idx)]);

    // R9: nothing enabled means no request
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (!irq_nc && !irq_cr && pend_none));

    // R9: no urgent sources means no urgent request
    p_no_cr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_q == '0) |-> !irq_cr);
endmodule

bind uic_core uic_core_chk #(.NSRC(NSRC), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .st_q      (st_q),
    .en_q      (en_q),
    .cr_q      (cr_q),
    .set_vec   (set_vec),
    .irq_nc    (irq_nc),
    .irq_cr    (irq_cr),
    .pend_idx  (pend_idx),
    .pend_none (pend_none)
);

// File: tb/tb_uic_core.sv
module tb_uic_core;
    localparam logic [2:0] A_STAT = 3'd0, A_EN = 3'd1, A_CRIT = 3'd2,
                           A_POL = 3'd3, A_TRIG = 3'd4, A_MSK = 3'd5, A_IDX = 3'd6;
    localparam int NV = 6;
    localparam logic [31:0] T_POL  [NV] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_0000,
                                            32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    localparam logic [31:0] T_SRC  [NV] = '{32'h8000_0001, 32'hFFFF_FFFE, 32'h00F0_00F0,
                                            32'h0000_0000, 32'h0001_0000, 32'h4000_0002};
    localparam logic [31:0] T_EN   [NV] = '{32'hFFFF_FFFF, 32'h0000_000F, 32'h0F0F_0F0F,
                                            32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hBFFF_FFFF};
    localparam logic [31:0] T_CRIT [NV] = '{32'h0, 32'h0, 32'h0000_0F00,
                                            32'h0, 32'hFFFF_FFFF, 32'h0};
    localparam logic [31:0] X_MSK  [NV] = '{32'h8000_0001, 32'h0000_0001, 32'h0000_0F0F,
                                            32'h0, 32'h0001_0000, 32'h0000_0002};
    localparam logic [31:0] X_IDX  [NV] = '{32'h0, 32'h1F, 32'h14, 32'h100, 32'hF, 32'h1E};
    localparam logic        X_NC   [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic        X_CR   [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_nc, irq_cr, pend_none;
    logic [4:0]  pend_idx;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    uic_core dut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_nc(irq_nc), .irq_cr(irq_cr), .pend_idx(pend_idx), .pend_none(pend_none)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R2 reset state
        rd(A_EN, rv);   chk("R2 enable", rv, 32'h0);
        rd(A_CRIT, rv); chk("R2 class", rv, 32'h0);
        rd(A_POL, rv);  chk("R2 polarity", rv, 32'h0);
        rd(A_TRIG, rv); chk("R2 trigger", rv, 32'h0);
        chk("R2 irq_nc", {31'b0, irq_nc}, 32'h0);
        chk("R2 irq_cr", {31'b0, irq_cr}, 32'h0);
        chk("R2 pend_none", {31'b0, pend_none}, 32'h1);

        // R1 R3 R8 R9 table of level vectors
        for (int i = 0; i < NV; i++) begin
            wr(A_TRIG, 32'h0);
            wr(A_POL, T_POL[i]);
            wr(A_EN, T_EN[i]);
            wr(A_CRIT, T_CRIT[i]);
            irq_src = T_SRC[i];
            idle(4);
            wr(A_STAT, 32'hFFFF_FFFF);
            rd(A_MSK, rv); chk($sformatf("R3 masked v%0d", i), rv, X_MSK[i]);
            rd(A_IDX, rv); chk($sformatf("R8 R1 index v%0d", i), rv, X_IDX[i]);
            chk($sformatf("R9 irq_nc v%0d", i), {31'b0, irq_nc}, {31'b0, X_NC[i]});
            chk($sformatf("R9 irq_cr v%0d", i), {31'b0, irq_cr}, {31'b0, X_CR[i]});
        end

        // R4 level latency
        wr(A_TRIG, 32'h0); wr(A_POL, 32'hFFFF_FFFF); wr(A_EN, 32'h0);
        irq_src = 32'h0;
        idle(4);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, rv); chk("R4 cleared", rv, 32'h0);
        irq_src = 32'h8000_0000;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(A_STAT, rv); chk("R4 not yet after two edges", rv, 32'h0);
        @(negedge clk);
        rd(A_STAT, rv); chk("R4 set on third edge", rv, 32'h8000_0000);

        // R7 level beats clear, sticky after drop
        wr(A_STAT, 32'h8000_0000);
        rd(A_STAT, rv); chk("R7 level wins clear", rv, 32'h8000_0000);
        irq_src = 32'h0;
        idle(4);
        rd(A_STAT, rv); chk("R7 sticky after drop", rv, 32'h8000_0000);
        wr(A_STAT, 32'h8000_0000);
        rd(A_STAT, rv); chk("R7 cleared when inactive", rv, 32'h0);

        // R5 R6 rising edge
        wr(A_TRIG, 32'hFFFF_FFFF);
        idle(4);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, rv); chk("R6 all-ones clear", rv, 32'h0);
        irq_src = 32'h1000_0000;
        idle(4);
        rd(A_STAT, rv); chk("R5 rising edge", rv, 32'h1000_0000);
        irq_src = 32'h0;
        idle(4);
        rd(A_STAT, rv); chk("R5 sticky edge", rv, 32'h1000_0000);
        wr(A_STAT, 32'hEFFF_FFFF);
        rd(A_STAT, rv); chk("R6 zero leaves bit", rv, 32'h1000_0000);
        wr(A_STAT, 32'h1000_0000);
        rd(A_STAT, rv); chk("R6 one clears bit", rv, 32'h0);

        // R5 falling edge and held input
        irq_src = 32'h0000_0020;
        idle(4);
        wr(A_POL, 32'hFFFF_FFDF);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, rv); chk("R5 cleared before fall", rv, 32'h0);
        irq_src = 32'h0;
        idle(4);
        rd(A_STAT, rv); chk("R5 falling edge", rv, 32'h0000_0020);
        wr(A_STAT, 32'h0000_0020);
        idle(3);
        rd(A_STAT, rv); chk("R5 held input no re-arm", rv, 32'h0);

        // R10 read-only addresses
        wr(A_EN, 32'h0000_FFFF);
        wr(A_MSK, 32'hFFFF_FFFF);
        wr(A_IDX, 32'hFFFF_FFFF);
        rd(A_EN, rv);   chk("R10 enable unchanged", rv, 32'h0000_FFFF);
        rd(A_STAT, rv); chk("R10 status unchanged", rv, 32'h0);
        rd(A_CRIT, rv); chk("R10 class unchanged", rv, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule